// File: doc/BRIEF.md
# Memory Fill Engine

The engine writes a repeated pattern over a block of memory without the CPU touching every word. Software loads a start address, an end address and a pattern value through a four-word register group. It then sets the go bit in the control word. The engine walks the region one 32-bit word at a time, in ascending order, and offers each word on a valid/ready write port. The go bit reads back as a busy flag and drops to 0 once the last word has been accepted. A system can place two instances side by side, each with its own register group.

The address registers hold byte addresses divided by eight, so every region starts and ends on an 8-byte boundary. The pattern unit is 16, 24 or 32 bits wide. In the 24-bit case, three-byte pixels run across word boundaries in the order red, green, blue, and the engine tracks the phase of that run from word to word.

Top module: `mem_fill_engine`

## Requirements
- R1: After reset, mem_valid is 0 and every register reads 0.
- R2: Register offsets are 0 = start, 1 = end, 2 = value, 3 = control. Start, end and value read back exactly as written. Control reads back only bit 0 (busy), bit 8 (24-bit select) and bit 9 (32-bit select); all other control bits read 0.
- R3: The byte address of the region is the register value shifted left by 3. Writes go to start<<3 first and step up by 4 each time. The last write is to (end<<3)-4, so the end address itself is never written.
- R4: Writing control with bit 0 = 1 while idle starts a fill, and mem_valid is asserted from the next cycle. Control bit 0 reads 1 until the cycle after the last accepted write, then reads 0.
- R5: A trigger with end <= start issues no write, and control bit 0 still reads 0 in the cycle after the trigger.
- R6: When bits 8 and 9 are both 0, each word is {value[15:0], value[15:0]}.
- R7: When bit 8 is 0 and bit 9 is 1, each word equals the full value register.
- R8: When bit 8 is 1, whatever bit 9 holds, bytes in ascending address order from the start repeat value[7:0], value[15:8], value[23:16]. Byte 0 is data[7:0].
- R9: A control write while busy has no effect: the fill keeps its pattern and the control mode bits read back unchanged.
- R10: While mem_valid is 1 and mem_ready is 0, mem_addr and mem_data hold, and no word is lost or repeated.
- R11: mem_be is 4'hF whenever mem_valid is 1.
- R12: Start, end and value are captured at the trigger. The pattern in flight comes from the value register at the moment of the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset within the register group |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, selected by reg_addr) |
| mem_valid | output | 1 | Write request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | AW | Byte address of the word being written |
| mem_data | output | 32 | Word to write, little-endian byte order |
| mem_be | output | 4 | Byte enables |

## Verification
The assertions assume that the memory side only samples mem_ready. They also assume that regions stay below the top of the address space, so the word pointer never wraps. The bench keeps regions small and well inside the address range. It toggles mem_ready in pseudo-random patterns and never ties the ready signal to the address. The bench issues at most one register access per cycle and sets up every region on an 8-byte boundary, which the register encoding requires. Control writes made while a fill is running are deliberate: they test that such writes are ignored.

// File: rtl/mem_fill_engine.sv
module mem_fill_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_data,
  output logic [3:0]    mem_be
);
  localparam int SW = AW - 3;

  logic [31:0]   start_r, end_r, val_r, pat;
  logic          sel24_r, sel32_r, m24, m32, busy;
  logic [AW-1:0] cur, lim;
  logic [1:0]    ph;

  wire [AW-1:0] s_byte = {start_r[SW-1:0], 3'b000};
  wire [AW-1:0] e_byte = {end_r[SW-1:0], 3'b000};
  wire trig = reg_we && reg_addr == 2'd3 && reg_wdata[0] && !busy;
  wire acc  = busy && mem_ready;
  wire [AW-1:0] nxt = cur + AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_r <= '0; end_r <= '0; val_r <= '0;
      sel24_r <= 1'b0; sel32_r <= 1'b0;
      m24 <= 1'b0; m32 <= 1'b0; busy <= 1'b0;
      cur <= '0; lim <= '0; pat <= '0; ph <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: start_r <= reg_wdata;
          2'd1: end_r   <= reg_wdata;
          2'd2: val_r   <= reg_wdata;
          default: if (!busy) begin
            sel24_r <= reg_wdata[8];
            sel32_r <= reg_wdata[9];
          end
        endcase
      end
      if (trig) begin
        cur  <= s_byte;
        lim  <= e_byte;
        pat  <= val_r;
        m24  <= reg_wdata[8];
        m32  <= reg_wdata[9];
        ph   <= 2'd0;
        busy <= e_byte > s_byte;
      end else if (acc) begin
        cur <= nxt;
        ph  <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        if (nxt >= lim) busy <= 1'b0;
      end
    end
  end

  wire [7:0] cr = pat[7:0];
  wire [7:0] cg = pat[15:8];
  wire [7:0] cb = pat[23:16];

  always_comb begin
    if (m24) begin
      case (ph)
        2'd0:    mem_data = {cr, cb, cg, cr};
        2'd1:    mem_data = {cg, cr, cb, cg};
        default: mem_data = {cb, cg, cr, cb};
      endcase
    end else if (m32) begin
      mem_data = pat;
    end else begin
      mem_data = {pat[15:0], pat[15:0]};
    end
  end

  assign mem_valid = busy;
  assign mem_addr  = cur;
  assign mem_be    = 4'hF;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = start_r;
      2'd1:    reg_rdata = end_r;
      2'd2:    reg_rdata = val_r;
      default: reg_rdata = {22'd0, sel32_r, sel24_r, 7'd0, busy};
    endcase
  end

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid || mem_addr == $past(mem_addr) + AW'(4));

  a_r11_full_be: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_be == 4'hF);

  a_r4_trigger_start: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd3 && reg_wdata[0] && !mem_valid
    |=> mem_valid == ($past(end_r[SW-1:0]) > $past(start_r[SW-1:0])));

  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && reg_we && reg_addr == 2'd3 |=> $stable(sel24_r) && $stable(sel32_r));

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
endmodule

// File: tb/test_mem_fill_engine.sv
module test_mem_fill_engine;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 2'd3;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_valid, mem_ready = 1;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0] mem_be;

  int checks = 0, errors = 0;
  bit rnd_ready = 0;
  string tag = "R1";
  int unsigned qa[$], qd[$];
  int unsigned sh_start = 0, sh_end = 0, sh_val = 0;

  always #5 clk = ~clk;

  mem_fill_engine #(.AW(AW)) i_mem_fill_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be));

  task automatic chk(input bit ok, input string t, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model_fill(input int unsigned ctl);
    int unsigned sb = sh_start << 3, eb = sh_end << 3;
    byte unsigned comp[3];
    comp[0] = sh_val[7:0]; comp[1] = sh_val[15:8]; comp[2] = sh_val[23:16];
    for (int unsigned a = sb; a < eb; a += 4) begin
      int unsigned w;
      if (ctl[8]) begin
        w = 0;
        for (int k = 0; k < 4; k++)
          w = w | (int'(comp[(a - sb + k) % 3]) << (8 * k));
      end else if (ctl[9]) w = sh_val;
      else w = {sh_val[15:0], sh_val[15:0]};
      qa.push_back(a);
      qd.push_back(w);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int unsigned d);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: sh_start = d;
      2'd1: sh_end = d;
      2'd2: sh_val = d;
      default: if (d[0] && qa.size() == 0) model_fill(d);
    endcase
    @(negedge clk); #1;
    reg_we = 0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, input int unsigned exp, input string t);
    @(negedge clk); #1;
    reg_addr = a;
    #2 chk(reg_rdata == exp, t, "readback", reg_rdata, exp);
    reg_addr = 2'd3;
  endtask

  task automatic wait_idle();
    while (qa.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int unsigned s, input int unsigned e,
                      input int unsigned v, input int unsigned ctl);
    wr(2'd0, s); wr(2'd1, e); wr(2'd2, v); wr(2'd3, ctl);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_valid == (qa.size() != 0), tag, "mem_valid", mem_valid, qa.size() != 0);
      if (mem_valid && qa.size() != 0) begin
        chk(mem_addr == qa[0], tag, "mem_addr", mem_addr, qa[0]);
        chk(mem_data == qd[0], tag, "mem_data", mem_data, qd[0]);
        chk(mem_be == 4'hF, "R11", "mem_be", mem_be, 4'hF);
      end
      if (!reg_we && reg_addr == 2'd3)
        chk(reg_rdata[0] == (qa.size() != 0), "R4", "busy bit", reg_rdata[0], qa.size() != 0);
      mem_ready = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
      if (mem_valid && mem_ready && qa.size() != 0) begin
        void'(qa.pop_front());
        void'(qd.pop_front());
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(mem_valid == 0, "R1", "reset mem_valid", mem_valid, 0);
    for (int i = 0; i < 4; i++) begin
      reg_addr = 2'(i);
      #1 chk(reg_rdata == 0, "R1", "reset reg", reg_rdata, 0);
    end
    reg_addr = 2'd3;
    rst_n = 1;
    repeat (2) @(negedge clk);

    tag = "R2";
    wr(2'd0, 32'h20); wr(2'd1, 32'h24); wr(2'd2, 32'hA1B2C3D4); wr(2'd3, 32'hFFFFFFFE);
    rd(2'd0, 32'h20, "R2"); rd(2'd1, 32'h24, "R2");
    rd(2'd2, 32'hA1B2C3D4, "R2"); rd(2'd3, 32'h300, "R2");

    tag = "R6";
    fill(32'h40, 32'h44, 32'h1234BEEF, 32'h1);
    wait_idle();
    rd(2'd3, 32'h0, "R4");

    tag = "R3";
    fill(32'h51, 32'h58, 32'h00005A5A, 32'h1);
    wait_idle();

    tag = "R7";
    rnd_ready = 1;
    fill(32'h80, 32'h86, 32'hCAFEF00D, 32'h201);
    wait_idle();

    tag = "R10";
    fill(32'h100, 32'h104, 32'h87654321, 32'h201);
    wait_idle();

    tag = "R8";
    fill(32'h200, 32'h206, 32'h00332211, 32'h301);
    wait_idle();
    fill(32'h300, 32'h303, 32'h00CCBBAA, 32'h101);
    wait_idle();

    tag = "R9";
    rnd_ready = 0;
    fill(32'h400, 32'h408, 32'h00F1E2D3, 32'h101);
    wr(2'd3, 32'h201);
    rd(2'd3, 32'h101, "R9");
    wait_idle();
    rd(2'd3, 32'h100, "R9");

    tag = "R12";
    fill(32'h500, 32'h504, 32'h11112222, 32'h201);
    wr(2'd2, 32'h99998888);
    wait_idle();

    tag = "R5";
    fill(32'h600, 32'h600, 32'h1, 32'h201);
    rd(2'd3, 32'h200, "R5");
    repeat (3) @(negedge clk);
    fill(32'h700, 32'h6F0, 32'h1, 32'h1);
    rd(2'd3, 32'h0, "R5");
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule